// File: doc/BRIEF.md
# DMA Channel Register and Interrupt Unit

This block is the software-visible control and status unit of a sixteen-channel DMA engine. A simple 32-bit register bus with word addressing reaches each channel's setup registers: buffer address, horizontal length, vertical length, a control word and a line stride. It also reaches four global bitmaps, one bit per channel: pending events, interrupt mask, channel halt and loop arming. The address generators sit outside this block. They take their setup from the exported register values, begin a transfer on a one-cycle kick, and report back with completion and mid-buffer pulses.

A transfer is launched by writing the address register last. That write produces the kick for the channel. Events from the generators are latched as pending bits, which software acknowledges by writing ones. One interrupt line is raised while any pending event is unmasked. Looping on a channel is armed only when two separate bits are both set, so a single stray write cannot arm it.

Top module: `dma_csr_block`

## Requirements
- R1: After reset every register reads zero, `irq` is low, and every strobe and exported setup value is zero.
- R2: Channel c's setup group is at word index 4·c. Word 0 holds the address (32 bits), word 1 the horizontal length and word 2 the vertical length (low 16 bits kept, read back zero-extended), and word 3 the control word (low 6 bits kept). Each reads back what was written.
- R3: Channel c's stride register is at word index 64 + c (byte 0x100 + 4·c). It keeps 16 bits and reads back zero-extended.
- R4: A write to channel c's address word makes `ch_start` equal to exactly bit c for the one cycle after the write. Writes to any other register leave `ch_start` at zero.
- R5: A pulse on `ch_done[c]` or `ch_half[c]` sets pending bit c, read at byte 0x144 (word 81). The bit stays set until it is cleared.
- R6: Writing to the pending word clears each bit written as 1. Bits written as 0 are unchanged.
- R7: If an event pulse and a write-1 clear of the same pending bit fall in the same cycle, the bit ends up set.
- R8: The mask at byte 0x148 (word 82) reads back as written. `irq` is high exactly when some pending bit and its mask bit are both 1.
- R9: Writing to byte 0x140 (word 80) drives `ch_stop` with the written low bits for the one cycle after the write, then zero. This word reads zero.
- R10: The loop word at byte 0x150 (word 84) stores all 32 bits. `ch_loop_en[n]` is high only when bit n and bit n+16 are both 1.
- R11: Reads of unmapped words (for example 0x14C, 0x154 and 0x180 to 0x1FC) return zero. Writes to them change no register.
- R12: The exported setup outputs equal the register contents: `ch_addr`, `ch_xlen`, `ch_ylen` and `ch_width` slices, with `ch_burst` taken from control bit 4 and `ch_dir` from control bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_waddr | input | 7 | Word address (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_waddr`, combinational |
| ch_done | input | 16 | Per-channel completion pulses |
| ch_half | input | 16 | Per-channel mid-buffer pulses |
| ch_start | output | 16 | One-cycle kick per channel |
| ch_stop | output | 16 | One-cycle halt per channel |
| ch_loop_en | output | 16 | Loop armed per channel |
| ch_burst | output | 16 | Burst mode per channel (control bit 4) |
| ch_dir | output | 16 | Direction per channel (control bit 5) |
| ch_addr | output | 512 | Address registers, channel c at bits [32c+31:32c] |
| ch_xlen | output | 256 | Horizontal lengths, 16 bits per channel |
| ch_ylen | output | 256 | Vertical lengths, 16 bits per channel |
| ch_width | output | 256 | Line strides, 16 bits per channel |
| irq | output | 1 | Combined interrupt |

## Verification
The bench sweeps every channel's five registers with distinct values. This catches a wrong stride or a swapped word offset, which would show up as one channel's data read back at a neighbour's address, or as a kick on the wrong channel or on a non-address write. The pending register is driven with a write-1 clear and an event in the same cycle. A design that let the clear win would silently drop an interrupt. Loop arming is tried with only the low half, only the high half and both halves set, because a design that ORs the pair would arm looping from half a setup. Unmapped words are written with all ones and then read, to show that their decode does not alias the status or stride words.

// File: rtl/dcsr_pkg.sv
package dcsr_pkg;

  localparam int BUS_AW = 7;    // word address width
  localparam int CH_MAX = 16;   // channel bitmap capacity
  localparam int LOOP_HI = 16;  // offset of second loop-arm half
  localparam int CTRL_W = 6;
  localparam int CTRL_BURST_BIT = 4;
  localparam int CTRL_DIR_BIT = 5;

  localparam logic [BUS_AW-1:0] W_STOP = 7'd80;  // byte 0x140
  localparam logic [BUS_AW-1:0] W_STAT = 7'd81;  // byte 0x144
  localparam logic [BUS_AW-1:0] W_MASK = 7'd82;  // byte 0x148
  localparam logic [BUS_AW-1:0] W_LOOP = 7'd84;  // byte 0x150

  typedef enum logic [2:0] {
    RK_NONE, RK_ADDR, RK_XLEN, RK_YLEN, RK_CTRL, RK_WIDTH
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e  kind;
    logic [3:0] ch;
    logic       g_stop;
    logic       g_stat;
    logic       g_mask;
    logic       g_loop;
  } dec_t;

  // pending update: clears first, new events win over clears
  function automatic logic [CH_MAX-1:0] pend_next(
    input logic [CH_MAX-1:0] cur, input logic [CH_MAX-1:0] clr,
    input logic [CH_MAX-1:0] evt);
    return (cur & ~clr) | evt;
  endfunction

  // loop arming needs both halves of the loop word
  function automatic logic [CH_MAX-1:0] loop_pairs(input logic [31:0] lw);
    return lw[CH_MAX-1:0] & lw[LOOP_HI +: CH_MAX];
  endfunction

endpackage

// File: rtl/dcsr_decode.sv
module dcsr_decode
  import dcsr_pkg::*;
#(
  parameter int NCH = 16
) (
  input  logic [BUS_AW-1:0] waddr,
  output dec_t              dec
);
  always_comb begin
    dec = '{kind: RK_NONE, ch: 4'd0, g_stop: 1'b0, g_stat: 1'b0,
            g_mask: 1'b0, g_loop: 1'b0};
    if (!waddr[6]) begin
      dec.ch = waddr[5:2];
      if (int'(waddr[5:2]) < NCH) begin
        unique case (waddr[1:0])
          2'd0: dec.kind = RK_ADDR;
          2'd1: dec.kind = RK_XLEN;
          2'd2: dec.kind = RK_YLEN;
          default: dec.kind = RK_CTRL;
        endcase
      end
    end else if (waddr[5:4] == 2'b00) begin
      dec.ch = waddr[3:0];
      if (int'(waddr[3:0]) < NCH) dec.kind = RK_WIDTH;
    end else begin
      dec.g_stop = (waddr == W_STOP);
      dec.g_stat = (waddr == W_STAT);
      dec.g_mask = (waddr == W_MASK);
      dec.g_loop = (waddr == W_LOOP);
    end
  end
endmodule

// File: rtl/dcsr_chan_bank.sv
module dcsr_chan_bank
  import dcsr_pkg::*;
#(
  parameter int NCH    = 16,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  reg_kind_e                     wr_kind,
  input  logic [3:0]                    wr_ch,
  input  logic [DATA_W-1:0]             wdata,
  output logic [NCH-1:0][DATA_W-1:0]    addr_q,
  output logic [NCH-1:0][LEN_W-1:0]     xlen_q,
  output logic [NCH-1:0][LEN_W-1:0]     ylen_q,
  output logic [NCH-1:0][LEN_W-1:0]     width_q,
  output logic [NCH-1:0][CTRL_W-1:0]    ctrl_q,
  output logic [NCH-1:0]                start
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic              hit;
    logic [DATA_W-1:0] a_r;
    logic [LEN_W-1:0]  x_r, y_r, w_r;
    logic [CTRL_W-1:0] c_r;
    logic              s_r;

    assign hit = wr_en && (wr_ch == 4'(c));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        a_r <= '0; x_r <= '0; y_r <= '0; w_r <= '0; c_r <= '0; s_r <= 1'b0;
      end else begin
        s_r <= hit && (wr_kind == RK_ADDR);
        if (hit) begin
          unique case (wr_kind)
            RK_ADDR:  a_r <= wdata;
            RK_XLEN:  x_r <= wdata[LEN_W-1:0];
            RK_YLEN:  y_r <= wdata[LEN_W-1:0];
            RK_CTRL:  c_r <= wdata[CTRL_W-1:0];
            RK_WIDTH: w_r <= wdata[LEN_W-1:0];
            default:  ;
          endcase
        end
      end
    end

    assign addr_q[c]  = a_r;
    assign xlen_q[c]  = x_r;
    assign ylen_q[c]  = y_r;
    assign width_q[c] = w_r;
    assign ctrl_q[c]  = c_r;
    assign start[c]   = s_r;
  end
endmodule

// File: rtl/dcsr_event_ctrl.sv
module dcsr_event_ctrl
  import dcsr_pkg::*;
#(
  parameter int NCH = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_stat,
  input  logic           wr_mask,
  input  logic           wr_stop,
  input  logic           wr_loop,
  input  logic [31:0]    wdata,
  input  logic [NCH-1:0] ch_done,
  input  logic [NCH-1:0] ch_half,
  output logic [NCH-1:0] pend_q,
  output logic [NCH-1:0] mask_q,
  output logic [31:0]    loop_q,
  output logic [NCH-1:0] stop_q,
  output logic [NCH-1:0] loop_en,
  output logic           irq
);
  logic [NCH-1:0] clr_bits;
  logic [NCH-1:0] evt_bits;
  logic [CH_MAX-1:0] pend_wide;
  logic [CH_MAX-1:0] pairs;

  assign clr_bits  = wr_stat ? wdata[NCH-1:0] : '0;
  assign evt_bits  = ch_done | ch_half;
  assign pend_wide = pend_next(CH_MAX'(pend_q), CH_MAX'(clr_bits), CH_MAX'(evt_bits));
  assign pairs     = loop_pairs(loop_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0; mask_q <= '0; loop_q <= '0; stop_q <= '0;
    end else begin
      pend_q <= pend_wide[NCH-1:0];
      stop_q <= wr_stop ? wdata[NCH-1:0] : '0;
      if (wr_mask) mask_q <= wdata[NCH-1:0];
      if (wr_loop) loop_q <= wdata;
    end
  end

  assign loop_en = pairs[NCH-1:0];
  assign irq     = |(pend_q & mask_q);
endmodule

// File: rtl/dma_csr_block.sv
module dma_csr_block
  import dcsr_pkg::*;
#(
  parameter int NCH    = 16,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_sel,
  input  logic                    bus_wr,
  input  logic [BUS_AW-1:0]       bus_waddr,
  input  logic [DATA_W-1:0]       bus_wdata,
  output logic [DATA_W-1:0]       bus_rdata,
  input  logic [NCH-1:0]          ch_done,
  input  logic [NCH-1:0]          ch_half,
  output logic [NCH-1:0]          ch_start,
  output logic [NCH-1:0]          ch_stop,
  output logic [NCH-1:0]          ch_loop_en,
  output logic [NCH-1:0]          ch_burst,
  output logic [NCH-1:0]          ch_dir,
  output logic [NCH*DATA_W-1:0]   ch_addr,
  output logic [NCH*LEN_W-1:0]    ch_xlen,
  output logic [NCH*LEN_W-1:0]    ch_ylen,
  output logic [NCH*LEN_W-1:0]    ch_width,
  output logic                    irq
);
  dec_t dec;
  logic wr_cyc;
  logic [NCH-1:0][DATA_W-1:0] addr_q;
  logic [NCH-1:0][LEN_W-1:0]  xlen_q, ylen_q, width_q;
  logic [NCH-1:0][CTRL_W-1:0] ctrl_q;
  logic [NCH-1:0] sts_q;   // pending events, named for the checker
  logic [NCH-1:0] ien_q;   // interrupt mask, named for the checker
  logic [31:0]    loop_q;

  assign wr_cyc = bus_sel && bus_wr;

  dcsr_decode #(.NCH(NCH)) u_dec (.waddr(bus_waddr), .dec(dec));

  dcsr_chan_bank #(.NCH(NCH), .DATA_W(DATA_W), .LEN_W(LEN_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_cyc), .wr_kind(dec.kind),
    .wr_ch(dec.ch), .wdata(bus_wdata), .addr_q(addr_q), .xlen_q(xlen_q),
    .ylen_q(ylen_q), .width_q(width_q), .ctrl_q(ctrl_q), .start(ch_start));

  dcsr_event_ctrl #(.NCH(NCH)) u_evt (
    .clk(clk), .rst_n(rst_n),
    .wr_stat(wr_cyc && dec.g_stat), .wr_mask(wr_cyc && dec.g_mask),
    .wr_stop(wr_cyc && dec.g_stop), .wr_loop(wr_cyc && dec.g_loop),
    .wdata(bus_wdata[31:0]), .ch_done(ch_done), .ch_half(ch_half),
    .pend_q(sts_q), .mask_q(ien_q), .loop_q(loop_q), .stop_q(ch_stop),
    .loop_en(ch_loop_en), .irq(irq));

  for (genvar c = 0; c < NCH; c++) begin : g_out
    assign ch_addr[c*DATA_W +: DATA_W] = addr_q[c];
    assign ch_xlen[c*LEN_W +: LEN_W]   = xlen_q[c];
    assign ch_ylen[c*LEN_W +: LEN_W]   = ylen_q[c];
    assign ch_width[c*LEN_W +: LEN_W]  = width_q[c];
    assign ch_burst[c] = ctrl_q[c][CTRL_BURST_BIT];
    assign ch_dir[c]   = ctrl_q[c][CTRL_DIR_BIT];
  end

  always_comb begin
    bus_rdata = '0;
    unique case (dec.kind)
      RK_ADDR:  bus_rdata = addr_q[dec.ch];
      RK_XLEN:  bus_rdata = DATA_W'(xlen_q[dec.ch]);
      RK_YLEN:  bus_rdata = DATA_W'(ylen_q[dec.ch]);
      RK_CTRL:  bus_rdata = DATA_W'(ctrl_q[dec.ch]);
      RK_WIDTH: bus_rdata = DATA_W'(width_q[dec.ch]);
      default: begin
        if (dec.g_stat) bus_rdata = DATA_W'(sts_q);
        if (dec.g_mask) bus_rdata = DATA_W'(ien_q);
        if (dec.g_loop) bus_rdata = DATA_W'(loop_q);
      end
    endcase
  end
endmodule

// File: rtl/dcsr_checker.sv
module dcsr_checker
  import dcsr_pkg::*;
#(
  parameter int NCH = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [BUS_AW-1:0] bus_waddr,
  input logic [NCH-1:0]    wmask,
  input logic [NCH-1:0]    ch_done,
  input logic [NCH-1:0]    ch_half,
  input logic [NCH-1:0]    ch_start,
  input logic [NCH-1:0]    ch_stop,
  input logic              irq,
  input logic [NCH-1:0]    sts_q,
  input logic [NCH-1:0]    ien_q
);
  a_r4_single_kick: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_start));

  a_r4_kick_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (|ch_start) |-> $past(bus_sel && bus_wr && !bus_waddr[6] && bus_waddr[1:0] == 2'd0));

  a_r5_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_done == '0 && ch_half == '0) |=> ((sts_q & ~$past(sts_q)) == '0));

  a_r6_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_waddr == W_STAT)
      |=> ((sts_q & $past(wmask & ~(ch_done | ch_half))) == '0));

  a_r7_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ((ch_done | ch_half) != '0)
      |=> ((sts_q & $past(ch_done | ch_half)) == $past(ch_done | ch_half)));

  a_r8_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == '0) |-> !irq);

  a_r9_stop_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (|ch_stop) |-> $past(bus_sel && bus_wr && bus_waddr == W_STOP));
endmodule

bind dma_csr_block dcsr_checker #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_waddr(bus_waddr), .wmask(bus_wdata[NCH-1:0]), .ch_done(ch_done),
  .ch_half(ch_half), .ch_start(ch_start), .ch_stop(ch_stop), .irq(irq),
  .sts_q(sts_q), .ien_q(ien_q));

// File: tb/test_dma_csr_block.sv
module test_dma_csr_block;
  localparam int NCH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [6:0] bus_waddr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NCH-1:0] ch_done = '0, ch_half = '0;
  logic [NCH-1:0] ch_start, ch_stop, ch_loop_en, ch_burst, ch_dir;
  logic [NCH*32-1:0] ch_addr;
  logic [NCH*16-1:0] ch_xlen, ch_ylen, ch_width;
  logic irq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  dma_csr_block i_dma_csr_block (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_waddr(bus_waddr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ch_done(ch_done), .ch_half(ch_half), .ch_start(ch_start),
    .ch_stop(ch_stop), .ch_loop_en(ch_loop_en), .ch_burst(ch_burst),
    .ch_dir(ch_dir), .ch_addr(ch_addr), .ch_xlen(ch_xlen),
    .ch_ylen(ch_ylen), .ch_width(ch_width), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // write completes at the negedge after the capturing edge
  task automatic wr(input int byte_ofs, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_waddr = 7'(byte_ofs >> 2); bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input int byte_ofs, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_waddr = 7'(byte_ofs >> 2);
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic pulse(input logic [NCH-1:0] dn, input logic [NCH-1:0] hf);
    @(negedge clk);
    ch_done = dn; ch_half = hf;
    @(negedge clk);
    ch_done = '0; ch_half = '0;
  endtask

  function automatic logic [31:0] pat(input int ch, input int k);
    return 32'h9E37_79B9 * 32'(ch * 8 + k + 1) ^ 32'h00FF_F00F;
  endfunction

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [NCH-1:0] exp_pend;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: every word reads zero, outputs idle
    for (int w = 0; w < 128; w++) begin
      rd(w * 4, v);
      chk("R1 reset read", v, 32'd0);
    end
    chk("R1 irq", 32'(irq), 32'd0);
    chk("R1 strobes", {ch_start, ch_stop}, 32'd0);
    chk("R1 addr0", ch_addr[31:0], 32'd0);

    // R2 R3 R4 R12: channel sweep
    for (int c = 0; c < NCH; c++) begin
      wr(c * 16 + 4, pat(c, 1));
      chk("R4 no kick on xlen", 32'(ch_start), 32'd0);
      wr(c * 16 + 8, pat(c, 2));
      wr(c * 16 + 12, pat(c, 3));
      chk("R4 no kick on ctrl", 32'(ch_start), 32'd0);
      wr(32'h100 + c * 4, pat(c, 4));
      chk("R4 no kick on stride", 32'(ch_start), 32'd0);
      wr(c * 16, pat(c, 0));
      chk("R4 kick", 32'(ch_start), 32'(1 << c));
      @(negedge clk);
      chk("R4 kick one cycle", 32'(ch_start), 32'd0);
    end
    for (int c = 0; c < NCH; c++) begin
      rd(c * 16, v);      chk("R2 addr", v, pat(c, 0));
      rd(c * 16 + 4, v);  chk("R2 xlen", v, pat(c, 1) & 32'hFFFF);
      rd(c * 16 + 8, v);  chk("R2 ylen", v, pat(c, 2) & 32'hFFFF);
      rd(c * 16 + 12, v); chk("R2 ctrl", v, pat(c, 3) & 32'h3F);
      rd(32'h100 + c * 4, v); chk("R3 stride", v, pat(c, 4) & 32'hFFFF);
      chk("R12 addr out", ch_addr[c*32 +: 32], pat(c, 0));
      chk("R12 xlen out", 32'(ch_xlen[c*16 +: 16]), pat(c, 1) & 32'hFFFF);
      chk("R12 ylen out", 32'(ch_ylen[c*16 +: 16]), pat(c, 2) & 32'hFFFF);
      chk("R12 stride out", 32'(ch_width[c*16 +: 16]), pat(c, 4) & 32'hFFFF);
      chk("R12 burst", 32'(ch_burst[c]), 32'(pat(c, 3)[4]));
      chk("R12 dir", 32'(ch_dir[c]), 32'(pat(c, 3)[5]));
    end

    // R11: unmapped words
    wr(32'h14C, 32'hFFFF_FFFF);
    wr(32'h154, 32'hFFFF_FFFF);
    wr(32'h180, 32'hFFFF_FFFF);
    wr(32'h1FC, 32'hFFFF_FFFF);
    rd(32'h14C, v); chk("R11 read 14C", v, 32'd0);
    rd(32'h154, v); chk("R11 read 154", v, 32'd0);
    rd(32'h180, v); chk("R11 read 180", v, 32'd0);
    rd(32'h144, v); chk("R11 pending untouched", v, 32'd0);
    rd(32'h148, v); chk("R11 mask untouched", v, 32'd0);
    rd(32'h150, v); chk("R11 loop untouched", v, 32'd0);
    rd(32'h100, v); chk("R11 stride untouched", v, pat(0, 4) & 32'hFFFF);

    // R5: events accumulate
    exp_pend = '0;
    for (int c = 0; c < NCH; c++) begin
      if (c % 2 == 0) pulse(NCH'(1 << c), '0);
      else pulse('0, NCH'(1 << c));
      exp_pend[c] = 1'b1;
      rd(32'h144, v);
      chk("R5 pending set", v, 32'(exp_pend));
    end
    chk("R8 masked irq low", 32'(irq), 32'd0);

    // R6: zero write no effect, ones clear
    wr(32'h144, 32'h0);
    rd(32'h144, v); chk("R6 zero write", v, 32'h0000_FFFF);
    wr(32'h144, 32'h0000_5A5A);
    rd(32'h144, v); chk("R6 partial clear", v, 32'h0000_A5A5);

    // R7: same-cycle event and clear
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_waddr = 7'(32'h144 >> 2); bus_wdata = 32'h0000_A5A5;
    ch_done = 16'h0001; ch_half = 16'h0004;  // bits 0 and 2 in the clear mask
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; ch_done = '0; ch_half = '0;
    rd(32'h144, v); chk("R7 event wins", v, 32'h0000_0005);

    // R8: mask readback and irq per channel
    wr(32'h144, 32'hFFFF);
    for (int c = 0; c < NCH; c++) begin
      wr(32'h148, 32'(1 << c));
      rd(32'h148, v); chk("R8 mask readback", v, 32'(1 << c));
      pulse(NCH'(1 << ((c + 1) % NCH)), '0);
      chk("R8 other channel no irq", 32'(irq), 32'd0);
      pulse('0, NCH'(1 << c));
      chk("R8 irq raised", 32'(irq), 32'd1);
      wr(32'h144, 32'hFFFF);
      chk("R8 irq drops on clear", 32'(irq), 32'd0);
    end
    wr(32'h148, 32'h0);

    // R9: stop strobe
    wr(32'h140, 32'h0000_8421);
    chk("R9 stop strobe", 32'(ch_stop), 32'h0000_8421);
    @(negedge clk);
    chk("R9 stop one cycle", 32'(ch_stop), 32'd0);
    rd(32'h140, v); chk("R9 stop reads zero", v, 32'd0);

    // R10: loop arming needs both halves
    wr(32'h150, 32'h0000_00FF);
    chk("R10 low half only", 32'(ch_loop_en), 32'd0);
    wr(32'h150, 32'h00FF_0000);
    chk("R10 high half only", 32'(ch_loop_en), 32'd0);
    wr(32'h150, 32'h0F3C_0FF0);
    chk("R10 both halves", 32'(ch_loop_en), 32'h0000_0F30);
    rd(32'h150, v); chk("R10 loop readback", v, 32'h0F3C_0FF0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule